// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block holds a 2048-byte bank of shared counters that processors update without locks. Every request on its single-cycle request port performs a complete read-modify-write. A load reads a counter, adds a small signed increment carried in the upper bits of the load address, writes the sum back and returns the value the counter held before the add. A store either adds its data to a counter or overwrites the counter with it, depending on one address bit.

Counters may be 8, 16, 32 or 64 bits wide and share one bank. The bank is organised as 64-bit words, and a narrower counter sits in the byte lanes of its word in big-endian order. Requests are accepted one per clock and complete in order. A request that lands on an offset not aligned to its size is flagged and leaves the bank untouched. A per-load wait flag from the address is passed through to the response for the requester's scheduler.

Top module: `atomic_counter_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ld_valid`, `ld_wait` and `req_err` are low and `ld_data` is zero.
- R2: A load accepted on a rising edge with `req_valid` high and `req_is_store` low gives `ld_valid` high for one cycle, starting at the next rising edge. `ld_data` holds the counter's value before the update, sign-extended to 64 bits.
- R3: A load adds the signed 22-bit increment in `req_addr[35:14]` to the counter and writes the sum back. The increment is sign-extended to the access width.
- R4: `req_size` selects the counter width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. `req_addr[10:0]` is the counter's byte offset.
- R5: Every sum wraps modulo 2^width, and no byte outside the addressed counter changes.
- R6: On a store, `req_addr[13]` = 0 adds the low width bits of `req_wdata` to the counter, and `req_addr[13]` = 1 overwrites the counter with those bits.
- R7: Byte order is big-endian: the byte at the lowest offset of a multi-byte counter is its most significant byte. A byte-wide access at offset o sees byte o of a wider value written there.
- R8: Requests are served one per cycle in arrival order. A request to a counter updated by the request just before it sees the updated value. Cycles without a request produce no response.
- R9: A 16-, 32- or 64-bit request whose offset is not a multiple of 2, 4 or 8 raises `req_err` in its response cycle and changes no counter. A misaligned load returns `ld_data` = 0.
- R10: On a load, `req_addr[13]` is returned on `ld_wait` together with the response. `ld_wait` is never high without `ld_valid`.
- R11: Stores raise no `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 36 | [10:0] byte offset, [13] store mode or load wait flag, [35:14] load increment |
| req_size | input | 2 | Counter width code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| req_wdata | input | 64 | Store operand; the low width bits are used |
| ld_valid | output | 1 | Load response valid |
| ld_data | output | 64 | Counter value before the update, sign-extended |
| ld_wait | output | 1 | Wait flag of the responding load |
| req_err | output | 1 | The responding request was misaligned |

## Verification
On every cycle the assertions check the request-to-response timing: each load gets a response one cycle after it is accepted, stores and idle cycles get none, misalignment decided from the port fields shows on `req_err`, a misaligned load returns zero data, and the wait flag travels with its load. What ends up in the bank can only be shown by the bench's scenarios, which compare each response against a byte-array model. These scenarios cover wrap-around, neighbouring bytes left intact, big-endian lane placement, store add against overwrite, and back-to-back requests to the same word that exercise the bypass path.

// File: rtl/fab_pkg.sv
package fab_pkg;
  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int LANE_W     = $clog2(WORD_BYTES);

  // Width code of a request (R4)
  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } fab_size_e;

  typedef struct packed {
    logic                is_store;
    logic                set_mode;
    logic                tag;
    fab_size_e           size;
    logic [LANE_W-1:0]   lane;
    logic [WORD_W-1:0]   operand;
  } fab_op_t;

  function automatic logic [WORD_W-1:0] size_mask(fab_size_e s);
    case (s)
      SZ_8:    return 64'h0000_0000_0000_00FF;
      SZ_16:   return 64'h0000_0000_0000_FFFF;
      SZ_32:   return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] sext_field(logic [WORD_W-1:0] v, fab_size_e s);
    case (s)
      SZ_8:    return {{56{v[7]}},  v[7:0]};
      SZ_16:   return {{48{v[15]}}, v[15:0]};
      SZ_32:   return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/fab_decode.sv
// Splits a request into word index, lane and operand, and checks alignment.
module fab_decode import fab_pkg::*; #(
  parameter  int BANK_BYTES = 2048,
  parameter  int INC_W      = 22,
  parameter  int INC_LSB    = 14,
  parameter  int MODE_BIT   = 13,
  localparam int OFF_W      = $clog2(BANK_BYTES),
  localparam int IDX_W      = OFF_W - LANE_W,
  localparam int AW         = INC_LSB + INC_W
) (
  input  logic              is_store,
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output fab_op_t           op,
  output logic              misaligned
);
  logic [LANE_W-1:0] lane;
  logic [LANE_W-1:0] align_bits;
  logic [WORD_W-1:0] inc_ext;
  logic              unused_gap;

  assign lane       = addr[LANE_W-1:0];
  assign idx        = addr[OFF_W-1:LANE_W];
  // Low offset bits that must be zero for this width (R9)
  assign align_bits = LANE_W'((32'd1 << size) - 32'd1);
  assign misaligned = |(lane & align_bits);
  // Signed increment widened to a full word (R3)
  assign inc_ext    = {{(WORD_W-INC_W){addr[AW-1]}}, addr[AW-1:INC_LSB]};
  // Offset bits above the bank size are not decoded; layout assumes MODE_BIT+1 == INC_LSB
  assign unused_gap = ^addr[MODE_BIT-1:OFF_W];

  always_comb begin
    op.is_store = is_store;
    op.set_mode = is_store & addr[MODE_BIT];
    op.tag      = ~is_store & addr[MODE_BIT];
    op.size     = fab_size_e'(size);
    op.lane     = lane;
    op.operand  = is_store ? wdata : inc_ext;
  end
endmodule

// File: rtl/fab_lane_alu.sv
// Extracts a big-endian field from a word, adds or replaces it, merges it back.
module fab_lane_alu import fab_pkg::*; (
  input  logic [WORD_W-1:0] old_word,
  input  fab_size_e         size,
  input  logic [LANE_W-1:0] lane,
  input  logic              set_mode,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] new_word,
  output logic [WORD_W-1:0] old_value
);
  localparam int SHW = $clog2(WORD_W);

  logic [LANE_W:0]   nbytes;
  logic [SHW-1:0]    shamt;
  logic [WORD_W-1:0] fmask;
  logic [WORD_W-1:0] old_f;
  logic [WORD_W-1:0] new_f;
  logic [WORD_W-1:0] ins;
  int                sh_bits;

  always_comb begin
    nbytes  = (LANE_W+1)'(1) << size;
    // Lowest offset is most significant (R7)
    sh_bits = (WORD_BYTES - int'(lane) - int'(nbytes)) * 8;
    if (sh_bits < 0) sh_bits = 0;
    shamt     = SHW'(sh_bits);
    fmask     = size_mask(size);
    old_f     = (old_word >> shamt) & fmask;
    // Modulo 2^width, no saturation (R5); add or overwrite (R6)
    new_f     = (set_mode ? operand : old_f + operand) & fmask;
    ins       = new_f << shamt;
    old_value = sext_field(old_f, size);
  end

  // One byte-select per lane; bytes outside the counter keep their value (R5)
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    localparam int HI = WORD_W - 1 - 8*b;
    logic hit;
    assign hit = ((LANE_W+1)'(b) >= {1'b0, lane}) &&
                 ((LANE_W+1)'(b) <  ({1'b0, lane} + nbytes));
    assign new_word[HI -: 8] = hit ? ins[HI -: 8] : old_word[HI -: 8];
  end
endmodule

// File: rtl/fab_store.sv
// Counter storage: one read port, one write port, read-first, block-RAM friendly.
module fab_store #(
  parameter  int DEPTH = 256,
  parameter  int WIDTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/atomic_counter_bank.sv
// Two-stage atomic update: stage 1 reads the word, stage 2 merges, writes back and responds.
module atomic_counter_bank import fab_pkg::*; #(
  parameter  int BANK_BYTES = 2048,
  parameter  int INC_W      = 22,
  parameter  int INC_LSB    = 14,
  parameter  int MODE_BIT   = 13,
  localparam int AW         = INC_LSB + INC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_store,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              ld_valid,
  output logic [WORD_W-1:0] ld_data,
  output logic              ld_wait,
  output logic              req_err
);
  localparam int OFF_W = $clog2(BANK_BYTES);
  localparam int IDX_W = OFF_W - LANE_W;
  localparam int DEPTH = BANK_BYTES / WORD_BYTES;

  logic [IDX_W-1:0]  dec_idx;
  fab_op_t           dec_op;
  logic              dec_mis;

  logic              s1_valid;
  logic [IDX_W-1:0]  s1_idx;
  fab_op_t           s1_op;
  logic              s1_err;

  logic [WORD_W-1:0] ram_q;
  logic              fwd_valid;
  logic [IDX_W-1:0]  fwd_idx;
  logic [WORD_W-1:0] fwd_word;

  logic [WORD_W-1:0] base_word;
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] old_val;
  logic              wr_en;

  fab_decode #(
    .BANK_BYTES (BANK_BYTES),
    .INC_W      (INC_W),
    .INC_LSB    (INC_LSB),
    .MODE_BIT   (MODE_BIT)
  ) u_decode (
    .is_store   (req_is_store),
    .addr       (req_addr),
    .size       (req_size),
    .wdata      (req_wdata),
    .idx        (dec_idx),
    .op         (dec_op),
    .misaligned (dec_mis)
  );

  fab_store #(
    .DEPTH (DEPTH),
    .WIDTH (WORD_W)
  ) u_store (
    .clk     (clk),
    .rd_en   (req_valid),
    .rd_idx  (dec_idx),
    .rd_data (ram_q),
    .wr_en   (wr_en),
    .wr_idx  (s1_idx),
    .wr_data (new_word)
  );

  // Stage 1 request register
  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
    if (req_valid) begin
      s1_idx <= dec_idx;
      s1_op  <= dec_op;
      s1_err <= dec_mis;
    end
  end

  // The storage read of a back-to-back request to the same word is one write stale (R8)
  assign base_word = (fwd_valid && (fwd_idx == s1_idx)) ? fwd_word : ram_q;
  // Misaligned requests never write (R9)
  assign wr_en     = s1_valid & ~s1_err;

  fab_lane_alu u_alu (
    .old_word  (base_word),
    .size      (s1_op.size),
    .lane      (s1_op.lane),
    .set_mode  (s1_op.set_mode),
    .operand   (s1_op.operand),
    .new_word  (new_word),
    .old_value (old_val)
  );

  always_ff @(posedge clk) begin
    if (rst) fwd_valid <= 1'b0;
    else     fwd_valid <= wr_en;
    fwd_idx  <= s1_idx;
    fwd_word <= new_word;
  end

  // Registered response (R1, R2, R9, R10, R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
      ld_wait  <= 1'b0;
      req_err  <= 1'b0;
    end else begin
      ld_valid <= s1_valid & ~s1_op.is_store;
      ld_data  <= (s1_valid && !s1_op.is_store && !s1_err) ? old_val : '0;
      ld_wait  <= s1_valid & s1_op.tag;
      req_err  <= s1_valid & s1_err;
    end
  end
endmodule

// File: rtl/fab_checker.sv
module fab_checker #(
  parameter int AW       = 36,
  parameter int MODE_BIT = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_is_store,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          ld_valid,
  input logic [63:0]   ld_data,
  input logic          ld_wait,
  input logic          req_err
);
  logic port_mis;
  assign port_mis = |(req_addr[2:0] & 3'((32'd1 << req_size) - 32'd1));

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!ld_valid && !ld_wait && !req_err && ld_data == 64'd0)); // R1

  AST_LOAD_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_store) |-> ##2 ld_valid); // R2

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> ##2 (!ld_valid && !req_err)); // R8

  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && port_mis) |-> ##2 req_err); // R9

  AST_ALIGNED_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !port_mis) |-> ##2 !req_err); // R9

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (ld_data == 64'd0)); // R9

  AST_WAIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_store) |-> ##2 (ld_wait == $past(req_addr[MODE_BIT], 2))); // R10

  AST_WAIT_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_wait |-> ld_valid); // R10

  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store) |-> ##2 !ld_valid); // R11
endmodule

bind atomic_counter_bank fab_checker #(
  .AW       (AW),
  .MODE_BIT (MODE_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_is_store (req_is_store),
  .req_addr     (req_addr),
  .req_size     (req_size),
  .ld_valid     (ld_valid),
  .ld_data      (ld_data),
  .ld_wait      (ld_wait),
  .req_err      (req_err)
);

// File: tb/atomic_counter_bank_tb.sv
`timescale 1ns/1ps
module atomic_counter_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_is_store = 1'b0;
  logic [35:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        ld_valid;
  logic [63:0] ld_data;
  logic        ld_wait;
  logic        req_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  atomic_counter_bank u_dut (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_is_store (req_is_store),
    .req_addr (req_addr), .req_size (req_size), .req_wdata (req_wdata),
    .ld_valid (ld_valid), .ld_data (ld_data), .ld_wait (ld_wait), .req_err (req_err)
  );

  // Behavioural model: a plain byte array, big-endian counters
  logic [7:0] bank [2048];
  logic       e1_v, e2_v, e1_w, e2_w, e1_e, e2_e;
  logic [63:0] e1_d, e2_d;
  string      t1, t2;

  function automatic logic [63:0] rd_be(int off, int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(bank[off+i]);
    return v;
  endfunction

  task automatic wr_be(int off, int n, logic [63:0] v);
    for (int i = 0; i < n; i++) bank[off+i] = 8'(v >> (8*(n-1-i)));
  endtask

  function automatic logic [63:0] sx(logic [63:0] v, int n);
    logic [63:0] m;
    if (n == 8) return v;
    m = (64'd1 << (8*n)) - 64'd1;
    v = v & m;
    if (v[8*n-1]) v = v | ~m;
    return v;
  endfunction

  function automatic logic [35:0] mk(int off, logic [21:0] inc, bit b13);
    return {inc, b13, 2'b00, 11'(off)};
  endfunction

  task automatic compare();
    checks++;
    if ({ld_valid, ld_data, ld_wait, req_err} !== {e2_v, e2_d, e2_w, e2_e}) begin
      errors++;
      $display("FAIL %s: actual v=%0b d=%h w=%0b e=%0b expected v=%0b d=%h w=%0b e=%0b",
               t2, ld_valid, ld_data, ld_wait, req_err, e2_v, e2_d, e2_w, e2_e);
    end
  endtask

  // One clock of stimulus; checks the response of the request two slots back
  task automatic cyc(bit v, bit st, logic [35:0] a, logic [1:0] sz, logic [63:0] wd, string tag);
    int n, off;
    logic er;
    logic [63:0] old, nv;
    @(negedge clk);
    compare();
    e2_v = e1_v; e2_d = e1_d; e2_w = e1_w; e2_e = e1_e; t2 = t1;
    req_valid = v; req_is_store = st; req_addr = a; req_size = sz; req_wdata = wd;
    e1_v = 1'b0; e1_d = '0; e1_w = 1'b0; e1_e = 1'b0; t1 = tag;
    if (v) begin
      n   = 1 << sz;
      off = int'(a[10:0]);
      er  = (off % n) != 0;
      old = rd_be(off, n);
      e1_e = er;
      if (st) begin
        nv = a[13] ? wd : old + wd;
      end else begin
        nv = old + {{42{a[35]}}, a[35:14]};
        e1_v = 1'b1;
        e1_w = a[13];
        e1_d = er ? 64'd0 : sx(old, n);
      end
      if (!er) wr_be(off, n, nv);
    end
  endtask

  task automatic ld(int off, logic [1:0] sz, logic [21:0] inc, bit tw, string tag);
    cyc(1'b1, 1'b0, mk(off, inc, tw), sz, 64'd0, tag);
  endtask

  task automatic st(int off, logic [1:0] sz, logic [63:0] d, bit set, string tag);
    cyc(1'b1, 1'b1, mk(off, 22'd0, set), sz, d, tag);
  endtask

  task automatic idle(int k, string tag);
    for (int i = 0; i < k; i++) cyc(1'b0, 1'b0, '0, 2'd0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) bank[i] = 8'h00;
    e1_v = 0; e2_v = 0; e1_w = 0; e2_w = 0; e1_e = 0; e2_e = 0;
    e1_d = '0; e2_d = '0; t1 = "R1"; t2 = "R1";
    repeat (4) @(negedge clk);
    checks++;  // R1 reset state
    if ({ld_valid, ld_data, ld_wait, req_err} !== 67'd0) begin
      errors++;
      $display("FAIL R1: actual %h expected 0", {ld_valid, ld_data, ld_wait, req_err});
    end
    rst = 1'b0;
    idle(2, "R1");
    // Clear the whole bank with 64-bit overwrites (R6)
    for (int i = 0; i < 256; i++) st(i*8, 2'd3, 64'd0, 1'b1, "R6");
    idle(2, "R6");
    // Byte counter: fetch then add (R2, R3)
    ld(3, 2'd0, 22'd5, 1'b0, "R2");
    idle(1, "R3");
    ld(3, 2'd0, 22'd0, 1'b0, "R3");
    // Negative increment on 16 bits wraps to all ones (R3, R5)
    ld(20, 2'd1, 22'h3FFFFF, 1'b0, "R5");
    ld(20, 2'd1, 22'd0, 1'b0, "R5");
    // Byte wrap 0xFF + 1, neighbour untouched (R5)
    st(40, 2'd0, 64'hFF, 1'b1, "R5");
    st(41, 2'd0, 64'h7E, 1'b1, "R5");
    ld(40, 2'd0, 22'd1, 1'b0, "R5");
    ld(40, 2'd1, 22'd0, 1'b0, "R5");
    // Widths: 32 and 64 bit with the largest positive increment (R4)
    st(64, 2'd2, 64'h7FFF_FFF0, 1'b1, "R4");
    ld(64, 2'd2, 22'h1FFFFF, 1'b0, "R4");
    ld(64, 2'd2, 22'd0, 1'b0, "R4");
    st(72, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R4");
    ld(72, 2'd3, 22'd2, 1'b0, "R4");
    ld(72, 2'd3, 22'd0, 1'b0, "R4");
    // Store add against overwrite (R6)
    st(96, 2'd2, 64'd100, 1'b1, "R6");
    st(96, 2'd2, 64'hFFFF_FFFF_0000_0007, 1'b0, "R6");
    ld(96, 2'd2, 22'd0, 1'b0, "R6");
    // Big-endian lanes (R7)
    st(128, 2'd3, 64'h0102_0304_0506_0708, 1'b1, "R7");
    idle(2, "R7");
    ld(128, 2'd0, 22'd0, 1'b0, "R7");
    ld(135, 2'd0, 22'd0, 1'b0, "R7");
    ld(130, 2'd1, 22'd0, 1'b0, "R7");
    ld(132, 2'd2, 22'd0, 1'b0, "R7");
    ld(129, 2'd0, 22'h10, 1'b0, "R7");
    ld(128, 2'd3, 22'd0, 1'b0, "R7");
    // Back-to-back on one word (R8)
    st(200, 2'd3, 64'd10, 1'b1, "R8");
    ld(200, 2'd3, 22'd1, 1'b0, "R8");
    ld(200, 2'd3, 22'd1, 1'b0, "R8");
    ld(204, 2'd2, 22'd3, 1'b0, "R8");
    ld(200, 2'd3, 22'd0, 1'b0, "R8");
    // Misaligned requests: flagged, bank unchanged (R9)
    st(256, 2'd3, 64'h1111_2222_3333_4444, 1'b1, "R9");
    ld(258, 2'd2, 22'd9, 1'b0, "R9");
    st(257, 2'd1, 64'hAAAA, 1'b1, "R9");
    ld(260, 2'd3, 22'd1, 1'b0, "R9");
    ld(256, 2'd3, 22'd0, 1'b0, "R9");
    // Wait flag on loads only (R10, R11)
    ld(300, 2'd0, 22'd1, 1'b1, "R10");
    st(301, 2'd0, 64'd4, 1'b1, "R11");
    ld(300, 2'd0, 22'd0, 1'b1, "R10");
    st(302, 2'd0, 64'd4, 1'b0, "R11");
    // Mixed traffic on a small region, back to back (R8)
    void'($urandom(7));
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) idle(1, "R8");
      else cyc(1'b1, r > 6, mk(int'($urandom_range(512, 543)), 22'($urandom), 1'($urandom)),
               2'($urandom), {$urandom, $urandom}, "R8");
    end
    idle(3, "R8");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule